// File: doc/BRIEF.md
# Scrolling Tile Layer Line Renderer

This block draws one background layer of a tile-based video pipeline into a scanline buffer. When it is started for a display row, it takes a snapshot of the row number and of the two scroll registers. It then walks the tiles that cover that row from left to right. For each tile it reads one entry from the tile map and then the matching 8-pixel row of pattern data. It writes one palette index per screen column into the line buffer. The vertical scroll picks both the tile-map row and the pixel row inside each tile. The horizontal scroll is split in two: its coarse part picks the first tile-map column, and its fine part (the low three bits) picks the first pixel drawn from that tile.

Each tile-map entry carries an index into pattern memory and a vertical-flip flag. When the flag is set, the tile's pixel rows are read bottom to top. The tile map wraps in both directions. One tile more than the screen width needs is fetched, so a non-zero fine scroll never leaves a gap at the right edge. Pixels that fall off either edge are not written. The block reads memory one request at a time, takes about ten cycles per tile, and pulses a done signal when the row is complete, well inside one display line.

Top module: `tl_layer_render`

## Requirements
- R1: While reset is held and after it is released, with no start pulse, `lb_we`, `done`, `tile_rd` and `pat_rd` stay low.
- R2: The tile-map address is `{map_row, map_col}`, row-major. `map_row` is `((row + scroll_y) mod 512) >> 3`. For the k-th tile fetched in a row (k = 0..40), `map_col` is `(scroll_x[8:3] + k) mod 64`, so both axes wrap.
- R3: A tile entry holds the pattern index in bits [7:0] and the vertical-flip flag in bit 8. The pattern address is `{index, line}`, where `line` is `(row + scroll_y) mod 8`. When the flag is set, `line` is replaced by `7 - line`, row by row.
- R4: A pattern word holds 8 pixels of 4 bits each. The leftmost pixel c = 0 sits in bits [3:0], and pixel c sits in bits [4c+3:4c].
- R5: Screen column x (0..319) receives the map pixel at horizontal map position `(scroll_x + x) mod 512`. The low three bits of `scroll_x` select the first pixel used from the first tile.
- R6: During one render, every line-buffer address 0..319 is written exactly once, in increasing order, and no address of 320 or above is written.
- R7: Line-buffer data is `{transparent, index}`: the palette index is in bits [3:0], and bit 4 is set exactly when the index is 0.
- R8: `done` is a single-cycle pulse, raised after the last line-buffer write and within 800 cycles of the cycle in which `start` was sampled.
- R9: A `start` pulse that arrives while a render is in progress is ignored. Changes to `row`, `scroll_x` or `scroll_y` after the start pulse has been sampled do not affect that render.
- R10: Memory reads follow this protocol: data from either RAM is valid in the cycle after its read strobe and holds until the next strobe. Each tile costs one tile-map read followed in the next cycle by one pattern read, so there are 41 of each per render.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin rendering one row (taken only when idle) |
| row | input | 8 | Display row number |
| scroll_x | input | 9 | Horizontal scroll in pixels (coarse bits [8:3], fine bits [2:0]) |
| scroll_y | input | 9 | Vertical scroll in pixels |
| tile_rd | output | 1 | Tile-map read strobe |
| tile_addr | output | 12 | Tile-map address {map_row, map_col} |
| tile_data | input | 9 | Tile entry {flip, index} returned one cycle after the strobe |
| pat_rd | output | 1 | Pattern read strobe |
| pat_addr | output | 11 | Pattern address {index, line} |
| pat_data | input | 32 | Eight 4-bit pixels returned one cycle after the strobe |
| lb_we | output | 1 | Line-buffer write enable |
| lb_addr | output | 9 | Line-buffer column |
| lb_data | output | 5 | {transparent, palette index} |
| done | output | 1 | One-cycle pulse at the end of the row |

## Verification
The bench sweeps every fine horizontal offset at both a low and a wrapping coarse offset, and every line within a tile with both flip settings. It also covers vertical scroll that wraps past the bottom of the map and the last display row. It compares all 320 columns against a model that works from map pixel coordinates.

- A renderer that applies the fine offset at fetch time, or that drops the extra tile, shows up as shifted columns or columns that are never written.
- A renderer that flips rows in pairs, or forgets to flip, returns pattern rows from the wrong line.
- A renderer that restarts on a second start pulse, or reads live scroll inputs, produces a second done or mismatched pixels. The bench checks this by driving a second start pulse and changing row and scroll while a render is under way.

// File: rtl/tl_pkg.sv
package tl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TILE,
        ST_PAT,
        ST_EMIT,
        ST_FIN
    } tl_state_e;
endpackage

// File: rtl/tl_map_addr.sv
// Tile-map address and in-tile line for the current fetch column.
module tl_map_addr #(
    parameter int TILE_LOG2 = 3,
    parameter int COLS_LOG2 = 6,
    parameter int ROWS_LOG2 = 6,
    parameter int ROW_W     = 8,
    parameter int CNT_W     = 6,
    localparam int SY_W     = ROWS_LOG2 + TILE_LOG2
) (
    input  logic [ROW_W-1:0]               row,
    input  logic [SY_W-1:0]                scroll_y,
    input  logic [COLS_LOG2-1:0]           sx_coarse,
    input  logic [CNT_W-1:0]               tile_cnt,
    output logic [ROWS_LOG2+COLS_LOG2-1:0] tile_addr,
    output logic [TILE_LOG2-1:0]           line
);
    logic [SY_W-1:0]      map_y;
    logic [COLS_LOG2-1:0] map_col;

    always_comb begin
        // power-of-two map: truncation gives the wrap
        map_y     = SY_W'(row) + scroll_y;
        map_col   = sx_coarse + COLS_LOG2'(tile_cnt);
        tile_addr = {map_y[SY_W-1:TILE_LOG2], map_col};
        line      = map_y[TILE_LOG2-1:0];
    end
endmodule

// File: rtl/tl_line_pick.sv
// Pattern address from a tile entry, with per-row vertical flip.
module tl_line_pick #(
    parameter int IDX_W     = 8,
    parameter int TILE_LOG2 = 3
) (
    input  logic [IDX_W:0]             entry,
    input  logic [TILE_LOG2-1:0]       line,
    output logic [IDX_W+TILE_LOG2-1:0] pat_addr
);
    logic [TILE_LOG2-1:0] line_eff;

    always_comb begin
        // inverting all line bits maps r to (TILE-1-r) exactly
        line_eff = entry[IDX_W] ? ~line : line;
        pat_addr = {entry[IDX_W-1:0], line_eff};
    end
endmodule

// File: rtl/tl_pix_slot.sv
// Picks one pixel of the fetched pattern row and places it on screen.
module tl_pix_slot #(
    parameter int TILE_LOG2 = 3,
    parameter int PIX_W     = 4,
    parameter int LINE_W    = 320,
    parameter int CNT_W     = 6,
    localparam int TILE     = 1 << TILE_LOG2,
    localparam int LB_AW    = $clog2(LINE_W),
    localparam int XW       = CNT_W + TILE_LOG2
) (
    input  logic [TILE*PIX_W-1:0] pat_word,
    input  logic [TILE_LOG2-1:0]  pix_idx,
    input  logic [CNT_W-1:0]      tile_cnt,
    input  logic [TILE_LOG2-1:0]  fine,
    output logic                  we,
    output logic [LB_AW-1:0]      addr,
    output logic [PIX_W:0]        data
);
    logic [XW-1:0]    pos;
    logic [XW-1:0]    fine_x;
    logic [XW-1:0]    rel;
    logic [PIX_W-1:0] pix;

    always_comb begin
        pos    = {tile_cnt, pix_idx};
        fine_x = XW'(fine);
        rel    = pos - fine_x;
        we     = (pos >= fine_x) && (rel < XW'(LINE_W));
        addr   = rel[LB_AW-1:0];
        pix    = pat_word[pix_idx*PIX_W +: PIX_W];
        data   = {(pix == '0), pix};
    end
endmodule

// File: rtl/tl_layer_render.sv
module tl_layer_render
    import tl_pkg::*;
#(
    parameter int LINE_W      = 320,
    parameter int LINES       = 240,
    parameter int TILE_LOG2   = 3,
    parameter int COLS_LOG2   = 6,
    parameter int ROWS_LOG2   = 6,
    parameter int IDX_W       = 8,
    parameter int PIX_W       = 4,
    parameter int LINE_CYCLES = 800,
    localparam int TILE   = 1 << TILE_LOG2,
    localparam int NTILES = LINE_W / TILE + 1,
    localparam int SX_W   = COLS_LOG2 + TILE_LOG2,
    localparam int SY_W   = ROWS_LOG2 + TILE_LOG2,
    localparam int ROW_W  = $clog2(LINES),
    localparam int TA_W   = ROWS_LOG2 + COLS_LOG2,
    localparam int TE_W   = IDX_W + 1,
    localparam int PA_W   = IDX_W + TILE_LOG2,
    localparam int PW     = TILE * PIX_W,
    localparam int LB_AW  = $clog2(LINE_W),
    localparam int CNT_W  = $clog2(NTILES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [ROW_W-1:0] row,
    input  logic [SX_W-1:0]  scroll_x,
    input  logic [SY_W-1:0]  scroll_y,
    output logic             tile_rd,
    output logic [TA_W-1:0]  tile_addr,
    input  logic [TE_W-1:0]  tile_data,
    output logic             pat_rd,
    output logic [PA_W-1:0]  pat_addr,
    input  logic [PW-1:0]    pat_data,
    output logic             lb_we,
    output logic [LB_AW-1:0] lb_addr,
    output logic [PIX_W:0]   lb_data,
    output logic             done
);
    typedef struct packed {
        tl_state_e            st;
        logic [ROW_W-1:0]     row;
        logic [SX_W-1:0]      sx;
        logic [SY_W-1:0]      sy;
        logic [CNT_W-1:0]     tcnt;
        logic [TILE_LOG2-1:0] pidx;
        logic                 we;
        logic [LB_AW-1:0]     addr;
        logic [PIX_W:0]       data;
        logic                 done;
    } regs_t;

    regs_t cur_q, nxt_d;

    logic [TILE_LOG2-1:0] line_w;
    logic                 slot_we;
    logic [LB_AW-1:0]     slot_addr;
    logic [PIX_W:0]       slot_data;

    tl_map_addr #(
        .TILE_LOG2(TILE_LOG2), .COLS_LOG2(COLS_LOG2), .ROWS_LOG2(ROWS_LOG2),
        .ROW_W(ROW_W), .CNT_W(CNT_W)
    ) map_i (
        .row(cur_q.row), .scroll_y(cur_q.sy),
        .sx_coarse(cur_q.sx[SX_W-1:TILE_LOG2]), .tile_cnt(cur_q.tcnt),
        .tile_addr(tile_addr), .line(line_w)
    );

    // line_w only depends on captured row/scroll, so it is still valid in ST_PAT
    tl_line_pick #(.IDX_W(IDX_W), .TILE_LOG2(TILE_LOG2)) pick_i (
        .entry(tile_data), .line(line_w), .pat_addr(pat_addr)
    );

    tl_pix_slot #(
        .TILE_LOG2(TILE_LOG2), .PIX_W(PIX_W), .LINE_W(LINE_W), .CNT_W(CNT_W)
    ) slot_i (
        .pat_word(pat_data), .pix_idx(cur_q.pidx), .tile_cnt(cur_q.tcnt),
        .fine(cur_q.sx[TILE_LOG2-1:0]),
        .we(slot_we), .addr(slot_addr), .data(slot_data)
    );

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.we   = 1'b0;
        nxt_d.done = 1'b0;
        unique case (cur_q.st)
            ST_IDLE: begin
                if (start) begin
                    nxt_d.row  = row;
                    nxt_d.sx   = scroll_x;
                    nxt_d.sy   = scroll_y;
                    nxt_d.tcnt = '0;
                    nxt_d.st   = ST_TILE;
                end
            end
            ST_TILE: nxt_d.st = ST_PAT;
            ST_PAT: begin
                nxt_d.pidx = '0;
                nxt_d.st   = ST_EMIT;
            end
            ST_EMIT: begin
                nxt_d.we   = slot_we;
                nxt_d.addr = slot_addr;
                nxt_d.data = slot_data;
                nxt_d.pidx = cur_q.pidx + 1'b1;
                if (cur_q.pidx == TILE_LOG2'(TILE - 1)) begin
                    if (cur_q.tcnt == CNT_W'(NTILES - 1)) begin
                        nxt_d.st = ST_FIN;
                    end else begin
                        nxt_d.tcnt = cur_q.tcnt + 1'b1;
                        nxt_d.st   = ST_TILE;
                    end
                end
            end
            ST_FIN: begin
                nxt_d.done = 1'b1;
                nxt_d.st   = ST_IDLE;
            end
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign tile_rd = (cur_q.st == ST_TILE);
    assign pat_rd  = (cur_q.st == ST_PAT);
    assign lb_we   = cur_q.we;
    assign lb_addr = cur_q.addr;
    assign lb_data = cur_q.data;
    assign done    = cur_q.done;

    // ---------------- checks ----------------
    localparam int BUD_W = $clog2(LINE_CYCLES + 2);
    logic [BUD_W-1:0] bud_q;
    logic [LB_AW-1:0] last_q;
    logic             have_q;

    always_ff @(posedge clk) begin
        if (!rst_n || cur_q.st == ST_IDLE) begin
            bud_q  <= '0;
            have_q <= 1'b0;
            last_q <= '0;
        end else begin
            if (bud_q != {BUD_W{1'b1}}) bud_q <= bud_q + 1'b1;
            if (lb_we) begin
                have_q <= 1'b1;
                last_q <= lb_addr;
            end
        end
    end

    // R8
    budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bud_q <= BUD_W'(LINE_CYCLES));
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R6
    lb_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lb_we |-> (lb_addr < LB_AW'(LINE_W)));
    // R6
    lb_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lb_we && have_q) |-> (lb_addr == last_q + 1'b1));
    // R10
    fetch_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tile_rd |=> pat_rd);
    // R9
    restart_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st != ST_IDLE && start) |=>
            (cur_q.row == $past(cur_q.row) && cur_q.sx == $past(cur_q.sx)));
endmodule

// File: tb/tl_layer_render_tb.sv
module tl_layer_render_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  row = '0;
    logic [8:0]  scroll_x = '0;
    logic [8:0]  scroll_y = '0;
    logic        tile_rd;
    logic [11:0] tile_addr;
    logic [8:0]  tile_data = '0;
    logic        pat_rd;
    logic [10:0] pat_addr;
    logic [31:0] pat_data = '0;
    logic        lb_we;
    logic [8:0]  lb_addr;
    logic [4:0]  lb_data;
    logic        done;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    tl_layer_render dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .row(row),
        .scroll_x(scroll_x), .scroll_y(scroll_y),
        .tile_rd(tile_rd), .tile_addr(tile_addr), .tile_data(tile_data),
        .pat_rd(pat_rd), .pat_addr(pat_addr), .pat_data(pat_data),
        .lb_we(lb_we), .lb_addr(lb_addr), .lb_data(lb_data), .done(done)
    );

    function automatic int map_idx(int trow, int tcol);
        return (trow * 7 + tcol * 3 + 1) % 256;
    endfunction
    function automatic bit map_flip(int trow, int tcol);
        return ((trow + tcol) % 3) == 0;
    endfunction
    function automatic int pat_pix(int idx, int r, int c);
        return (idx + r * 5 + c * 3) % 16;
    endfunction

    // memory models: data one cycle after strobe, held otherwise
    always_ff @(posedge clk) begin
        if (tile_rd) begin
            tile_data <= {map_flip(int'(tile_addr[11:6]), int'(tile_addr[5:0])),
                          8'(map_idx(int'(tile_addr[11:6]), int'(tile_addr[5:0])))};
        end
        if (pat_rd) begin
            for (int c = 0; c < 8; c++)
                pat_data[c*4 +: 4] <= 4'(pat_pix(int'(pat_addr[10:3]), int'(pat_addr[2:0]), c));
        end
    end

    function automatic logic [4:0] exp_lb(int r, int sx, int sy, int x);
        int mx, my, trow, tcol, ln, idx, pix;
        mx = (sx + x) % 512;
        my = (r + sy) % 512;
        trow = my / 8;
        tcol = mx / 8;
        ln = my % 8;
        if (map_flip(trow, tcol)) ln = 7 - ln;
        idx = map_idx(trow, tcol);
        pix = pat_pix(idx, ln, mx % 8);
        return {(pix == 0), 4'(pix)};
    endfunction

    int         wr_cnt [320];
    logic [4:0] wr_val [320];
    int bad_addr = 0;
    int done_cnt = 0;
    int trd_cnt = 0;
    int prd_cnt = 0;

    always @(negedge clk) begin
        if (lb_we) begin
            if (lb_addr < 9'd320) begin
                wr_cnt[lb_addr] = wr_cnt[lb_addr] + 1;
                wr_val[lb_addr] = lb_data;
            end else begin
                bad_addr = bad_addr + 1;
            end
        end
        if (done) done_cnt = done_cnt + 1;
        if (tile_rd) trd_cnt = trd_cnt + 1;
        if (pat_rd) prd_cnt = prd_cnt + 1;
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic render(input int r, input int sx, input int sy, input bit disturb);
        int cyc;
        int pix_bad;
        int once_bad;
        int trans_seen;
        for (int i = 0; i < 320; i++) begin
            wr_cnt[i] = 0;
            wr_val[i] = '0;
        end
        bad_addr = 0; done_cnt = 0; trd_cnt = 0; prd_cnt = 0;
        @(negedge clk);
        row = 8'(r); scroll_x = 9'(sx); scroll_y = 9'(sy); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (done_cnt == 0 && cyc < 2000) begin
            if (disturb && cyc == 60) begin
                // R9: second start and changed inputs mid-render
                start = 1'b1; row = 8'(r + 17); scroll_x = 9'(sx + 123); scroll_y = 9'(sy + 45);
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        check(cyc <= 800, "R8 done within line budget", cyc, 800);
        repeat (20) @(negedge clk);
        check(done_cnt == 1, "R8/R9 single done pulse", done_cnt, 1);
        check(bad_addr == 0, "R6 no writes beyond line", bad_addr, 0);
        check(trd_cnt == 41 && prd_cnt == 41, "R10 one tile and pattern read per tile",
              trd_cnt * 100 + prd_cnt, 4141);
        once_bad = 0;
        pix_bad = 0;
        trans_seen = 0;
        for (int x = 0; x < 320; x++) begin
            logic [4:0] e;
            if (wr_cnt[x] != 1) once_bad++;
            e = exp_lb(r, sx, sy, x);
            if (e[4]) trans_seen++;
            checks++;
            if (wr_val[x] !== e) begin
                errors++;
                pix_bad++;
                if (pix_bad <= 4)
                    $display("FAIL R2/R3/R4/R5/R7 row=%0d sx=%0d sy=%0d x=%0d actual=%0h expected=%0h",
                             r, sx, sy, x, wr_val[x], e);
            end
        end
        check(once_bad == 0, "R6 each column written once", once_bad, 0);
        if (trans_seen > 0)
            check(1'b1, "R7 transparent pixels present", trans_seen, trans_seen);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) begin
            @(negedge clk);
            check(!lb_we && !done && !tile_rd && !pat_rd, "R1 quiet in reset",
                  {lb_we, done, tile_rd, pat_rd}, 0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        repeat (5) begin
            @(negedge clk);
            check(!lb_we && !done && !tile_rd && !pat_rd, "R1 quiet after reset",
                  {lb_we, done, tile_rd, pat_rd}, 0);
        end
        // R5: every fine offset, low and wrapping coarse offset
        for (int f = 0; f < 8; f++) render(10, f, 0, 1'b0);
        for (int f = 0; f < 8; f++) render(3, 60 * 8 + f, 5, 1'b0);
        // R3: every line within a tile, mixed flip entries
        for (int l = 0; l < 8; l++) render(16 + l, 13, 0, 1'b0);
        // R2: vertical wrap and last row
        render(20, 77, 500, 1'b0);
        render(239, 511, 511, 1'b0);
        // R9: restart and input changes ignored
        render(100, 203, 37, 1'b1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule